// File: doc/BRIEF.md
# SMBus Receive Byte Buffer

This block sits between an SMBus slave byte engine and a host-visible status/data register. The engine hands over each received byte, marks the first byte of a transfer, and signals the end of the transfer with a completion code (success, checksum error, early stop or timeout). The bytes wait in a five-entry queue. The host reads one 32-bit register that shows the oldest byte with its flags. Each read taken while a byte is shown removes that byte.

The register shows the data byte, a valid flag, a first-byte flag, a done flag and a 3-bit completion code. Done rises with the last byte of a transfer. Done stays set after that byte is read, and only a write of one to the done bit clears it. Until then the buffer accepts no new transfer. After an error, the host empties the queue by reading until done shows, then clears done. If a sixth byte arrives while the queue holds five, that byte is lost and the transfer ends with the overflow code. A separate control register has a soft reset bit that clears itself.

Top module: `smb_rx_buffer`

## Requirements
- R1: The queue holds up to 5 bytes and returns them in arrival order. Register bits 7:0 show the oldest byte. A host read (rd_i) while bit 8 is 1 removes that byte, and the next one is shown after the clock edge.
- R2: Bit 8 (ready) is 1 exactly when at least one byte is queued. When it is 0, bits 7:0 read zero and a host read changes nothing.
- R3: Bit 10 (first) is 1 while the shown byte was pushed with sof_i high.
- R4: Bit 9 (done) is 1 while the shown byte is the last byte of its transfer. After that byte is read, done stays 1 until a register write with bit 9 = 1. A write with bit 9 = 0 leaves it set.
- R5: Bits 13:11 hold the completion code whenever done is 1, and read 0 otherwise. The codes are 000 OK, 001 checksum error, 010 overflow, 011 unexpected stop and 100 timeout. The value comes from end_code_i.
- R6: A byte pushed while 5 are queued is discarded. That transfer then ends with code 010, whatever end_code_i carries.
- R7: An end event (end_vld_i) marks the most recently accepted byte of the open transfer as last. This includes a byte pushed in the same cycle. If no byte of the transfer is still queued, because all have been read or the only one is read in that same cycle, done rises at once with the code and ready stays 0.
- R8: Bytes and end events are dropped in three cases: while done is 1, while a last-marked byte is still queued, and for bytes without sof_i when no transfer is open.
- R9: Writing control bit 0 = 1 sets that bit for one cycle. It then clears itself, and at the same edge the queue empties and done, the code and any open transfer clear.
- R10: Register bits 31:14 and control bits 31:1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Engine pushes a received byte |
| byte_i | input | 8 | Received byte |
| sof_i | input | 1 | Pushed byte starts a transfer |
| end_vld_i | input | 1 | End of transfer event |
| end_code_i | input | 3 | Completion code of the ending transfer |
| rd_i | input | 1 | Host read strobe of the status/data register |
| wr_i | input | 1 | Host write strobe of the status/data register |
| wdata_i | input | 32 | Host write data, bit 9 clears done |
| rdata_o | output | 32 | Status/data register value |
| ctl_wr_i | input | 1 | Host write strobe of the control register |
| ctl_wdata_i | input | 32 | Control write data, bit 0 soft reset |
| ctl_rdata_o | output | 32 | Control register value |

## Verification
The engine's end event can land in the same cycle as the host read that removes the only queued byte of the transfer. In that case there is nothing left to mark as last. The bench pushes a single first byte, then in one cycle raises rd_i and end_vld_i with a checksum error code. It then expects done set, code 001 and ready low. The bench also covers a byte pushed together with the end event, and shows that this byte comes out as both last and done.

// File: rtl/smb_rx_pkg.sv
package smb_rx_pkg;
  typedef enum logic [2:0] {
    RX_OK   = 3'd0,
    RX_PEC  = 3'd1,
    RX_OVF  = 3'd2,
    RX_STOP = 3'd3,
    RX_TOUT = 3'd4
  } rx_code_e;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              first;
    logic              last;
    rx_code_e          code;
  } rx_entry_t;
endpackage

// File: rtl/smb_rx_store.sv
module smb_rx_store
  import smb_rx_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  rx_entry_t       push_ent_i,
  input  logic            pop_i,
  input  logic            mark_i,
  input  rx_code_e        mark_code_i,
  output rx_entry_t       head_o,
  output logic [CW-1:0]   cnt_o,
  output logic            empty_o,
  output logic            full_o
);
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, tail_ptr;
  logic [CW-1:0] cnt_q;
  rx_entry_t     slots [DEPTH];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // slot written by the most recent push
  assign tail_ptr = (wr_ptr_q == '0) ? PW'(DEPTH - 1) : wr_ptr_q - PW'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_entry_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (clr_i) begin
        slot_q <= '0;
      end else if (push_i && wr_ptr_q == PW'(i)) begin
        slot_q <= push_ent_i;
      end else if (mark_i && tail_ptr == PW'(i)) begin
        slot_q.last <= 1'b1;
        slot_q.code <= mark_code_i;
      end
    end
    assign slots[i] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = slots[rd_ptr_q];
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/smb_rx_ctrl.sv
module smb_rx_ctrl
  import smb_rx_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              sof_i,
  input  logic              end_vld_i,
  input  rx_code_e          end_code_i,
  input  logic              rd_i,
  input  logic              w1c_done_i,
  input  logic              empty_i,
  input  logic              full_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              head_last_i,
  input  rx_code_e          head_code_i,
  output logic              push_o,
  output rx_entry_t         push_ent_o,
  output logic              pop_o,
  output logic              mark_o,
  output rx_code_e          mark_code_o,
  output logic              done_o,
  output rx_code_e          status_o
);
  logic     open_q, ovf_q, pend_q, done_q;
  rx_code_e status_q;

  logic     start, start_ok, live, push_try, ovf_now, ovf_any;
  logic     end_take, rem_nz, mark_new, direct, last_pop;
  rx_code_e end_code;

  assign pop_o    = rd_i && !empty_i;
  assign last_pop = pop_o && head_last_i;
  assign start    = byte_vld_i && sof_i;
  // one transfer in flight: blocked while done or a closed transfer waits
  assign start_ok = !done_q && !pend_q;
  assign live     = start ? start_ok : open_q;
  assign push_try = byte_vld_i && live;
  assign push_o   = push_try && !full_i;
  assign ovf_now  = push_try && full_i;
  assign ovf_any  = (start ? 1'b0 : ovf_q) || ovf_now;
  assign end_take = end_vld_i && live;
  assign end_code = ovf_any ? RX_OVF : end_code_i;

  // entries of this transfer left once the current pop is done
  assign rem_nz   = pop_o ? (cnt_i > CW'(1)) : (cnt_i != '0);
  assign mark_new = end_take && push_o;
  assign mark_o   = end_take && !push_o && rem_nz;
  assign direct   = end_take && !push_o && !rem_nz;
  assign mark_code_o = end_code;

  always_comb begin
    push_ent_o.data  = byte_i;
    push_ent_o.first = sof_i;
    push_ent_o.last  = mark_new;
    push_ent_o.code  = mark_new ? end_code : RX_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      ovf_q    <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= RX_OK;
    end else if (clr_i) begin
      open_q   <= 1'b0;
      ovf_q    <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= RX_OK;
    end else begin
      if (end_take)   open_q <= 1'b0;
      else if (start) open_q <= start_ok;

      ovf_q <= end_take ? 1'b0 : (live ? ovf_any : 1'b0);

      if (mark_new || mark_o) pend_q <= 1'b1;
      else if (last_pop)      pend_q <= 1'b0;

      if (last_pop) begin
        done_q   <= 1'b1;
        status_q <= head_code_i;
      end else if (direct) begin
        done_q   <= 1'b1;
        status_q <= end_code;
      end else if (w1c_done_i) begin
        done_q   <= 1'b0;
        status_q <= RX_OK;
      end
    end
  end

  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/smb_rx_regview.sv
module smb_rx_regview
  import smb_rx_pkg::*;
(
  input  rx_entry_t   head_i,
  input  logic        empty_i,
  input  logic        done_i,
  input  rx_code_e    status_i,
  output logic [31:0] rdata_o
);
  logic     ready, first, done, head_last;
  logic [DATA_W-1:0] data;
  rx_code_e st;

  assign ready     = !empty_i;
  assign head_last = ready && head_i.last;
  assign data      = ready ? head_i.data : '0;
  assign first     = ready && head_i.first;
  assign done      = done_i || head_last;
  assign st        = head_last ? head_i.code : (done_i ? status_i : RX_OK);

  assign rdata_o = {18'b0, st, first, done, ready, data};
endmodule

// File: rtl/smb_rx_buffer.sv
module smb_rx_buffer
  import smb_rx_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        sof_i,
  input  logic        end_vld_i,
  input  logic [2:0]  end_code_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        ctl_wr_i,
  input  logic [31:0] ctl_wdata_i,
  output logic [31:0] ctl_rdata_o
);
  rx_entry_t     head, push_ent;
  rx_code_e      mark_code, status_q;
  logic          push, pop, mark, empty, full, done_q, srst_q;
  logic [CW-1:0] cnt;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[31:10], wdata_i[8:0], ctl_wdata_i[31:1]};

  // soft reset: one-cycle pulse, clears receive logic and itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         srst_q <= 1'b0;
    else if (srst_q)                     srst_q <= 1'b0;
    else if (ctl_wr_i && ctl_wdata_i[0]) srst_q <= 1'b1;
  end
  assign ctl_rdata_o = {31'b0, srst_q};

  smb_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_q),
    .push_i      (push),
    .push_ent_i  (push_ent),
    .pop_i       (pop),
    .mark_i      (mark),
    .mark_code_i (mark_code),
    .head_o      (head),
    .cnt_o       (cnt),
    .empty_o     (empty),
    .full_o      (full)
  );

  smb_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_q),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .sof_i       (sof_i),
    .end_vld_i   (end_vld_i),
    .end_code_i  (rx_code_e'(end_code_i)),
    .rd_i        (rd_i),
    .w1c_done_i  (wr_i && wdata_i[9]),
    .empty_i     (empty),
    .full_i      (full),
    .cnt_i       (cnt),
    .head_last_i (!empty && head.last),
    .head_code_i (head.code),
    .push_o      (push),
    .push_ent_o  (push_ent),
    .pop_o       (pop),
    .mark_o      (mark),
    .mark_code_o (mark_code),
    .done_o      (done_q),
    .status_o    (status_q)
  );

  smb_rx_regview u_view (
    .head_i   (head),
    .empty_i  (empty),
    .done_i   (done_q),
    .status_i (status_q),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/smb_rx_buffer_chk.sv
module smb_rx_buffer_chk #(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          wr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic [CW-1:0] cnt,
  input logic          done_q,
  input logic          srst_q
);
  assert_depth_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  assert_ready_tracks_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[8] == (cnt != '0));

  assert_done_after_last_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rdata_o[8] && rdata_o[9] && !srst_q) |=> rdata_o[9]);

  assert_done_clear_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> ($past(wr_i && wdata_i[9]) || $past(srst_q)));

  assert_status_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q) && !rdata_o[8]) |-> $stable(rdata_o[13:11]));

  assert_srst_self_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (!srst_q && cnt == '0 && !done_q));
endmodule

bind smb_rx_buffer smb_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .cnt     (cnt),
  .done_q  (done_q),
  .srst_q  (srst_q)
);

// File: tb/sim_smb_rx_buffer.sv
`timescale 1ns/1ps
module sim_smb_rx_buffer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        sof_i = 1'b0;
  logic        end_vld_i = 1'b0;
  logic [2:0]  end_code_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ctl_wr_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic [31:0] ctl_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  smb_rx_buffer u0 (.*);

  localparam logic [3:0] OP_NOP = 4'd0, OP_PUSH = 4'd1, OP_END = 4'd2, OP_READ = 4'd3,
                         OP_W1C = 4'd4, OP_W0 = 4'd5, OP_PUSH_END = 4'd6,
                         OP_READ_END = 4'd7, OP_SRST = 4'd8;

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  arg;
    logic        sof;
    logic [13:0] exp;
    logic [3:0]  req;
  } vec_t;

  // expected register: status 13:11, first 10, done 9, ready 8, data 7:0
  function automatic logic [13:0] rv(input logic [2:0] st, input logic f, input logic d,
                                     input logic r, input logic [7:0] dat);
    return {st, f, d, r, dat};
  endfunction

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{OP_PUSH,     8'hA1, 1'b1, rv(0,1,0,1,8'hA1), 4'd3},  // R3
    '{OP_PUSH,     8'hA2, 1'b0, rv(0,1,0,1,8'hA1), 4'd1},  // R1
    '{OP_END,      8'h00, 1'b0, rv(0,1,0,1,8'hA1), 4'd7},  // R7
    '{OP_READ,     8'h00, 1'b0, rv(0,0,1,1,8'hA2), 4'd4},  // R4
    '{OP_READ,     8'h00, 1'b0, rv(0,0,1,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hB0, 1'b1, rv(0,0,1,0,8'h00), 4'd8},  // R8
    '{OP_END,      8'h01, 1'b0, rv(0,0,1,0,8'h00), 4'd8},
    '{OP_W0,       8'h00, 1'b0, rv(0,0,1,0,8'h00), 4'd4},
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hB1, 1'b1, rv(0,1,0,1,8'hB1), 4'd3},
    '{OP_END,      8'h01, 1'b0, rv(1,1,1,1,8'hB1), 4'd5},  // R5
    '{OP_READ,     8'h00, 1'b0, rv(1,0,1,0,8'h00), 4'd5},
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hC1, 1'b1, rv(0,1,0,1,8'hC1), 4'd1},
    '{OP_PUSH,     8'hC2, 1'b0, rv(0,1,0,1,8'hC1), 4'd1},
    '{OP_PUSH,     8'hC3, 1'b0, rv(0,1,0,1,8'hC1), 4'd1},
    '{OP_PUSH,     8'hC4, 1'b0, rv(0,1,0,1,8'hC1), 4'd1},
    '{OP_PUSH,     8'hC5, 1'b0, rv(0,1,0,1,8'hC1), 4'd1},
    '{OP_PUSH,     8'hC6, 1'b0, rv(0,1,0,1,8'hC1), 4'd6},  // R6 sixth byte
    '{OP_END,      8'h00, 1'b0, rv(0,1,0,1,8'hC1), 4'd6},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,0,1,8'hC2), 4'd1},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,0,1,8'hC3), 4'd1},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,0,1,8'hC4), 4'd1},
    '{OP_READ,     8'h00, 1'b0, rv(2,0,1,1,8'hC5), 4'd6},
    '{OP_READ,     8'h00, 1'b0, rv(2,0,1,0,8'h00), 4'd6},
    '{OP_READ,     8'h00, 1'b0, rv(2,0,1,0,8'h00), 4'd2},  // R2
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hD1, 1'b1, rv(0,1,0,1,8'hD1), 4'd3},
    '{OP_PUSH,     8'hD2, 1'b0, rv(0,1,0,1,8'hD1), 4'd1},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,0,1,8'hD2), 4'd3},
    '{OP_END,      8'h04, 1'b0, rv(4,0,1,1,8'hD2), 4'd5},
    '{OP_READ,     8'h00, 1'b0, rv(4,0,1,0,8'h00), 4'd5},
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hE1, 1'b1, rv(0,1,0,1,8'hE1), 4'd3},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd2},
    '{OP_END,      8'h03, 1'b0, rv(3,0,1,0,8'h00), 4'd7},
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'hF1, 1'b1, rv(0,1,0,1,8'hF1), 4'd3},
    '{OP_PUSH_END, 8'hF2, 1'b0, rv(0,1,0,1,8'hF1), 4'd7},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,1,1,8'hF2), 4'd7},
    '{OP_READ,     8'h00, 1'b0, rv(0,0,1,0,8'h00), 4'd4},
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'h71, 1'b1, rv(0,1,0,1,8'h71), 4'd3},
    '{OP_READ_END, 8'h01, 1'b0, rv(1,0,1,0,8'h00), 4'd7},  // R7 end with last pop
    '{OP_W1C,      8'h00, 1'b0, rv(0,0,0,0,8'h00), 4'd4},
    '{OP_PUSH,     8'h55, 1'b0, rv(0,0,0,0,8'h00), 4'd8}   // R8 no open transfer
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req,
                     input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d step %0d: got %h expected %h", req, idx, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] arg, input logic sof,
                      input logic [13:0] exp, input int req, input int idx);
    case (op)
      OP_PUSH:     begin byte_vld_i = 1; byte_i = arg; sof_i = sof; end
      OP_END:      begin end_vld_i = 1; end_code_i = arg[2:0]; end
      OP_READ:     rd_i = 1;
      OP_W1C:      begin wr_i = 1; wdata_i = 32'h0000_0200; end
      OP_W0:       begin wr_i = 1; wdata_i = 32'hFFFF_FDFF; end
      OP_PUSH_END: begin byte_vld_i = 1; byte_i = arg; sof_i = sof;
                         end_vld_i = 1; end_code_i = 3'd0; end
      OP_READ_END: begin rd_i = 1; end_vld_i = 1; end_code_i = arg[2:0]; end
      OP_SRST:     begin ctl_wr_i = 1; ctl_wdata_i = 32'h1; end
      default: ;
    endcase
    @(posedge clk_i);
    #2;
    byte_vld_i = 0; sof_i = 0; end_vld_i = 0; rd_i = 0; wr_i = 0;
    ctl_wr_i = 0; wdata_i = '0; ctl_wdata_i = '0;
    #1;
    chk(rdata_o, {18'b0, exp}, req, idx);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(posedge clk_i); #3;
    chk(rdata_o, 32'h0, 2, 0);       // R2 reset state, R10 upper bits
    chk(ctl_rdata_o, 32'h0, 10, 0);  // R10

    for (int i = 0; i < NV; i++)
      step(VECS[i].op, VECS[i].arg, VECS[i].sof, VECS[i].exp, int'(VECS[i].req), i + 1);

    // R9 soft reset with done set and a rejected transfer pending
    step(OP_PUSH, 8'h81, 1'b1, rv(0,1,0,1,8'h81), 3, 100);
    step(OP_END,  8'h00, 1'b0, rv(0,1,1,1,8'h81), 4, 101);
    step(OP_READ, 8'h00, 1'b0, rv(0,0,1,0,8'h00), 4, 102);
    step(OP_PUSH, 8'h82, 1'b1, rv(0,0,1,0,8'h00), 8, 103);
    step(OP_SRST, 8'h00, 1'b0, rv(0,0,1,0,8'h00), 9, 104);
    chk(ctl_rdata_o, 32'h1, 9, 104);  // R9 bit visible for one cycle
    step(OP_NOP,  8'h00, 1'b0, rv(0,0,0,0,8'h00), 9, 105);
    chk(ctl_rdata_o, 32'h0, 9, 105);  // R9 self-cleared
    step(OP_PUSH, 8'h91, 1'b1, rv(0,1,0,1,8'h91), 9, 106);
    // R9 soft reset with bytes queued
    step(OP_PUSH, 8'h92, 1'b0, rv(0,1,0,1,8'h91), 1, 107);
    step(OP_SRST, 8'h00, 1'b0, rv(0,1,0,1,8'h91), 9, 108);
    step(OP_NOP,  8'h00, 1'b0, rv(0,0,0,0,8'h00), 9, 109);
    step(OP_READ, 8'h00, 1'b0, rv(0,0,0,0,8'h00), 2, 110);
    // R6 overflow overrides a non-OK end code
    step(OP_PUSH, 8'h31, 1'b1, rv(0,1,0,1,8'h31), 3, 111);
    for (int k = 0; k < 5; k++)
      step(OP_PUSH, 8'h32 + 8'(k), 1'b0, rv(0,1,0,1,8'h31), 6, 112 + k);
    step(OP_END,  8'h04, 1'b0, rv(0,1,0,1,8'h31), 6, 117);
    for (int k = 0; k < 4; k++)
      step(OP_READ, 8'h00, 1'b0, (k == 3) ? rv(2,0,1,1,8'h35) : rv(0,0,0,1,8'h32 + 8'(k)),
           6, 118 + k);
    chk(ctl_rdata_o, 32'h0, 10, 122);  // R10

    finish_run();
  end
endmodule